// File: doc/BRIEF.md
# Clock-Synchronous Serial Transmit Channel

This block is the transmit half of a clock-synchronized serial link. Bytes arrive from a bus-side write strobe into a one-byte holding buffer. They move into a separate shift register as soon as that register is free, and then leave on a single data line, least significant bit first. Each data change happens on a falling serial-clock edge, so the far end can sample on the rising edge. The data line idles high.

In master mode the block makes the serial clock from a baud tick: one tick for the low phase and one for the high phase, eight pulses per byte. It starts each byte only after it sees the far end's active-low ready line low on a tick. If another byte is already waiting when a byte ends, it follows with no idle cycle on the busy flag. In slave mode the block follows an external clock, which passes through a two-stage synchronizer. It drives an active-low ready output while a byte waits in the shift register, and the busy flag drops after every byte. The transmit enable gates all activity. A receive-enable request that arrives with it blocks transmission and is reported as a conflict.

Top module: `sync_ser_tx`

## Requirements
- R1: While the effective transmit enable is 0, nothing moves from the buffer to the shift register, no shifting occurs, and busy_o, sdo_o and the internal progress of a byte hold their values. A byte written in this state stays buffered.
- R2: When tx_en_i and rx_en_i are both 1, conflict_o is 1, transmission behaves as disabled (as in R1), and sclk_oe_o is 0.
- R3: A write sets buf_empty_o to 0 on the next cycle. When the shift register is idle and transmission is enabled, the buffered byte moves into the shift register on the following edge, and buf_empty_o returns to 1 unless a new write arrives in that same cycle.
- R4: busy_o is 1 from the cycle a byte enters the shift register until the cycle after its last rising serial-clock edge.
- R5: In master mode, when a byte is buffered at the moment the current byte finishes, the next byte loads on that same edge and busy_o stays 1 with no gap.
- R6: In slave mode, busy_o returns to 0 for at least one cycle after every byte, even when the buffer holds the next byte.
- R7: Bits leave LSB first. sdo_o changes only on a falling serial-clock event and holds through the following rising event. In the idle state with transmission enabled, sdo_o is driven to 1.
- R8: In master mode each byte gives exactly 8 low pulses on sclk_o. Each low phase and each high phase ends on a baud tick. The first falling edge waits for a tick while rdy_ni is 0.
- R9: In slave mode, rdy_no is 0 from the load of a byte until the 8th rising edge of sclk_i is recognized, and 1 otherwise. In master mode rdy_no is 1.
- R10: sclk_oe_o is 1 only in master mode with transmission effectively enabled. rdy_oe_o is 1 only in slave mode.
- R11: In slave mode an sclk_i edge takes effect after two synchronizer stages and one edge-detect register: a change sampled at clock edge k updates the state on edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable |
| rx_en_i | input | 1 | Receive-enable request from the shared link |
| master_i | input | 1 | 1 = master mode, 0 = slave mode |
| baud_tick_i | input | 1 | One-cycle baud tick, used in master mode |
| wr_i | input | 1 | Write strobe for the transmit buffer |
| wr_data_i | input | DATA_W | Byte to write |
| buf_empty_o | output | 1 | Transmit buffer empty |
| busy_o | output | 1 | A byte is being transmitted |
| conflict_o | output | 1 | Transmit and receive both requested |
| sclk_i | input | 1 | Serial clock input (slave mode) |
| sclk_o | output | 1 | Serial clock output (master mode), idles high |
| sclk_oe_o | output | 1 | Output enable for the serial clock pin |
| rdy_ni | input | 1 | Far-end ready, active low (master mode) |
| rdy_no | output | 1 | Ready to the far end, active low (slave mode) |
| rdy_oe_o | output | 1 | Output enable for the ready pin |
| sdo_o | output | 1 | Serial data out |

## Verification
A wrong phase or bit counter shows at the ports within one baud tick in master mode: an extra or missing sclk_o pulse, or a byte rebuilt from sdo_o that does not match what was written. In slave mode the same fault shows within three system clocks of the external edge that should end the byte. A buffer flag out of step shows on buf_empty_o or busy_o in the very cycle it goes wrong, because a behavioural model compares every output on every clock. Gaps or the lack of gaps between bytes are counted from busy_o falling edges over multi-byte runs in both modes.

// File: rtl/sync_ser_tx_pkg.sv
package sync_ser_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_LOW  = 2'd2,
    ST_HIGH = 2'd3
  } tx_state_e;
endpackage

// File: rtl/sync_ser_tx_buf.sv
module sync_ser_tx_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (wr_i) begin
        full_q <= 1'b1;
        data_q <= wr_data_i;
      end else if (take_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  a_r3_fill_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> full_o);
  a_r3_empty_after_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !wr_i) |=> !full_o);
endmodule

// File: rtl/sync_ser_tx_edge.sv
module sync_ser_tx_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic fall_o,
  output logic rise_o
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[CHAIN_W-2:0], sclk_i};
  end

  // synced level vs. its previous value
  assign fall_o = chain_q[CHAIN_W-1] & ~chain_q[CHAIN_W-2];
  assign rise_o = ~chain_q[CHAIN_W-1] & chain_q[CHAIN_W-2];

  a_r11_edges_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fall_o && rise_o));
endmodule

// File: rtl/sync_ser_tx_shift.sv
module sync_ser_tx_shift
  import sync_ser_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              master_i,
  input  logic              tick_i,
  input  logic              rdy_ni,
  input  logic              s_fall_i,
  input  logic              s_rise_i,
  input  logic              buf_full_i,
  input  logic [DATA_W-1:0] buf_data_i,
  output logic              take_o,
  output logic              busy_o,
  output logic              sdo_o,
  output logic              sclk_o,
  output logic              rdy_no
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  tx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic              sdo_q;
  logic              fall_ev, rise_ev, last_bit, done_ev, reload;

  always_comb begin
    if (master_i) begin
      fall_ev = tick_i & (((state_q == ST_WAIT) & ~rdy_ni) | (state_q == ST_HIGH));
      rise_ev = tick_i & (state_q == ST_LOW);
    end else begin
      fall_ev = s_fall_i & ((state_q == ST_WAIT) | (state_q == ST_HIGH));
      rise_ev = s_rise_i & (state_q == ST_LOW);
    end
  end

  assign last_bit = (cnt_q == LAST_BIT);
  assign done_ev  = active_i & rise_ev & last_bit;
  // master chains the next byte without returning to idle
  assign reload   = done_ev & master_i & buf_full_i;
  assign take_o   = (active_i & (state_q == ST_IDLE) & buf_full_i) | reload;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      sdo_q   <= 1'b1;
    end else if (active_i) begin
      unique case (state_q)
        ST_IDLE: begin
          sdo_q <= 1'b1;
          if (buf_full_i) begin
            state_q <= ST_WAIT;
            sh_q    <= buf_data_i;
            cnt_q   <= '0;
          end
        end
        ST_WAIT, ST_HIGH: begin
          if (fall_ev) begin
            sdo_q   <= sh_q[0];
            sh_q    <= sh_q >> 1;
            state_q <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (rise_ev) begin
            if (!last_bit) begin
              cnt_q   <= cnt_q + 1'b1;
              state_q <= ST_HIGH;
            end else if (reload) begin
              sh_q    <= buf_data_i;
              cnt_q   <= '0;
              state_q <= ST_WAIT;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign sdo_o  = sdo_q;
  assign sclk_o = ~(master_i & (state_q == ST_LOW));
  assign rdy_no = ~(~master_i & (state_q != ST_IDLE));

  a_r1_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> ($stable(sdo_o) && $stable(busy_o)));
  a_r5_master_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_ev && master_i && buf_full_i) |=> busy_o);
  a_r6_slave_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_ev && !master_i) |=> !busy_o);
  a_r7_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && state_q == ST_IDLE) |=> sdo_o);
  a_r7_data_held_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && rise_ev) |=> $stable(sdo_o));
  a_r8_tick_paced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !tick_i) |=> $stable(sclk_o));
  a_r9_ready_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_ev && !master_i) |=> rdy_no);
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              master_i,
  input  logic              baud_tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              buf_empty_o,
  output logic              busy_o,
  output logic              conflict_o,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  input  logic              rdy_ni,
  output logic              rdy_no,
  output logic              rdy_oe_o,
  output logic              sdo_o
);
  logic              active;
  logic              take, buf_full;
  logic [DATA_W-1:0] buf_data;
  logic              s_fall, s_rise;

  // half-duplex: a receive request blocks transmit
  assign active     = tx_en_i & ~rx_en_i;
  assign conflict_o = tx_en_i & rx_en_i;

  sync_ser_tx_buf #(.DATA_W(DATA_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .take_i    (take),
    .full_o    (buf_full),
    .data_o    (buf_data)
  );

  sync_ser_tx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .fall_o (s_fall),
    .rise_o (s_rise)
  );

  sync_ser_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .master_i   (master_i),
    .tick_i     (baud_tick_i),
    .rdy_ni     (rdy_ni),
    .s_fall_i   (s_fall),
    .s_rise_i   (s_rise),
    .buf_full_i (buf_full),
    .buf_data_i (buf_data),
    .take_o     (take),
    .busy_o     (busy_o),
    .sdo_o      (sdo_o),
    .sclk_o     (sclk_o),
    .rdy_no     (rdy_no)
  );

  assign buf_empty_o = ~buf_full;
  assign sclk_oe_o   = master_i & active;
  assign rdy_oe_o    = ~master_i;

  a_r2_refused_no_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |-> !sclk_oe_o);
  a_r2_refused_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conflict_o && !busy_o) |=> !busy_o);
  a_r10_single_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sclk_oe_o && rdy_oe_o));
endmodule

// File: tb/sync_ser_tx_tb_top.sv
module sync_ser_tx_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_en_i = 1'b0, rx_en_i = 1'b0, master_i = 1'b1;
  logic       baud_tick_i = 1'b0, wr_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       sclk_i = 1'b1, rdy_ni = 1'b0;
  logic       buf_empty_o, busy_o, conflict_o, sclk_o, sclk_oe_o, rdy_no, rdy_oe_o, sdo_o;

  int total = 0, bad = 0;
  bit cmp_en = 1'b0;

  always #4 clk_i = ~clk_i;

  sync_ser_tx dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_en_i(tx_en_i), .rx_en_i(rx_en_i),
    .master_i(master_i), .baud_tick_i(baud_tick_i), .wr_i(wr_i), .wr_data_i(wr_data_i),
    .buf_empty_o(buf_empty_o), .busy_o(busy_o), .conflict_o(conflict_o),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o), .rdy_ni(rdy_ni),
    .rdy_no(rdy_no), .rdy_oe_o(rdy_oe_o), .sdo_o(sdo_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // baud tick: every third clock
  int tick_cnt = 0;
  always @(negedge clk_i) begin
    tick_cnt = (tick_cnt == 2) ? 0 : tick_cnt + 1;
    baud_tick_i = (tick_cnt == 2);
  end

  // behavioural reference: phase 0 idle, 1 waiting, 2 clock low, 3 clock high
  bit   m_full, m_sdo, m_take, m_act, m_fall, m_rise, s_fall, s_rise;
  logic [7:0] m_buf;
  int   m_phase;
  bit   bits[$];
  bit   hist[3];

  task automatic m_load();
    bits.delete();
    for (int i = 0; i < 8; i++) bits.push_back(m_buf[i]);
    m_phase = 1;
    m_take = 1'b1;
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_full = 0; m_buf = 0; m_phase = 0; m_sdo = 1; bits.delete();
      hist[0] = 1; hist[1] = 1; hist[2] = 1;
    end else begin
      m_act = tx_en_i && !rx_en_i;
      m_take = 0;
      // R11: an edge sampled two clocks back takes effect now
      s_fall = hist[2] && !hist[1];
      s_rise = !hist[2] && hist[1];
      if (master_i) begin
        m_fall = baud_tick_i && ((m_phase == 1 && !rdy_ni) || m_phase == 3);
        m_rise = baud_tick_i && m_phase == 2;
      end else begin
        m_fall = s_fall && (m_phase == 1 || m_phase == 3);
        m_rise = s_rise && m_phase == 2;
      end
      if (m_act) begin
        if (m_phase == 0) begin
          m_sdo = 1;
          if (m_full) m_load();
        end else if (m_fall) begin
          m_sdo = bits.pop_front();
          m_phase = 2;
        end else if (m_rise) begin
          if (bits.size() == 0) begin
            if (master_i && m_full) m_load();
            else m_phase = 0;
          end else m_phase = 3;
        end
      end
      if (wr_i) begin m_full = 1; m_buf = wr_data_i; end
      else if (m_take) m_full = 0;
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = sclk_i;
    end
  end

  // per-clock comparison and monitors
  int   busy_falls = 0;
  bit   prev_busy = 0, prev_sclk = 1;
  bit   cap[$];
  always @(posedge clk_i) begin
    #2;
    if (rst_ni && cmp_en) begin
      chk("R3", buf_empty_o, !m_full);
      chk("R4 R11", busy_o, m_phase != 0);
      chk("R7", sdo_o, m_sdo);
      chk("R8", sclk_o, !(master_i && m_phase == 2));
      chk("R9", rdy_no, !(!master_i && m_phase != 0));
      chk("R10", sclk_oe_o, master_i && tx_en_i && !rx_en_i);
      chk("R10", rdy_oe_o, !master_i);
      chk("R2", conflict_o, tx_en_i && rx_en_i);
      if (prev_busy && !busy_o) busy_falls++;
      if (master_i && !prev_sclk && sclk_o) cap.push_back(sdo_o);
    end
    prev_busy = busy_o;
    prev_sclk = sclk_o;
  end

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk_i); wr_i = 1; wr_data_i = d;
    @(negedge clk_i); wr_i = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!busy_o && t < 200) begin @(negedge clk_i); t++; end
    while (busy_o && t < 5000) begin @(negedge clk_i); t++; end
    repeat (2) @(negedge clk_i);
  endtask

  task automatic wait_empty();
    int t = 0;
    while (!buf_empty_o && t < 5000) begin @(negedge clk_i); t++; end
  endtask

  function automatic logic [7:0] cap_byte(input int idx);
    logic [7:0] b = 0;
    for (int i = 0; i < 8; i++) b[i] = cap[idx*8 + i];
    return b;
  endfunction

  task automatic slave_byte(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sclk_i = 0; repeat (5) @(negedge clk_i);
      b[i] = sdo_o;
      sclk_i = 1; repeat (5) @(negedge clk_i);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk_i);
    chk("R3 reset", buf_empty_o, 1);
    chk("R4 reset", busy_o, 0);
    chk("R7 reset", sdo_o, 1);
    chk("R9 reset", rdy_no, 1);
    rst_ni = 1; cmp_en = 1;
    repeat (2) @(negedge clk_i);

    // R1: disabled, byte stays buffered
    write_byte(8'hA5);
    repeat (20) @(negedge clk_i);
    chk("R1 busy", busy_o, 0);
    chk("R1 buffered", buf_empty_o, 0);
    chk("R1 no clock", sclk_oe_o, 0);

    // R2: both enables refused
    tx_en_i = 1; rx_en_i = 1;
    repeat (10) @(negedge clk_i);
    chk("R2 conflict", conflict_o, 1);
    chk("R2 no start", busy_o, 0);
    chk("R2 still buffered", buf_empty_o, 0);
    cap.delete();
    rx_en_i = 0;
    wait_done();
    chk("R8 pulses", cap.size(), 8);
    chk("R7 lsb first", cap_byte(0), 8'hA5);

    // R8: master waits for far-end ready
    rdy_ni = 1; cap.delete();
    write_byte(8'h3C);
    repeat (30) @(negedge clk_i);
    chk("R8 held busy", busy_o, 1);
    chk("R8 no pulses", cap.size(), 0);
    chk("R8 clock idle", sclk_o, 1);
    rdy_ni = 0;
    wait_done();
    chk("R8 pulses", cap.size(), 8);
    chk("R7 byte", cap_byte(0), 8'h3C);

    // R5: master back-to-back with no busy gap
    cap.delete(); busy_falls = 0;
    write_byte(8'h81); wait_empty();
    write_byte(8'h7E); wait_empty();
    write_byte(8'hC3);
    wait_done();
    chk("R5 one busy fall", busy_falls, 1);
    chk("R8 pulses", cap.size(), 24);
    chk("R7 byte0", cap_byte(0), 8'h81);
    chk("R7 byte1", cap_byte(1), 8'h7E);
    chk("R7 byte2", cap_byte(2), 8'hC3);

    // slave mode
    master_i = 0;
    repeat (4) @(negedge clk_i);
    chk("R9 idle high", rdy_no, 1);
    chk("R10 rdy out", rdy_oe_o, 1);
    chk("R10 sclk in", sclk_oe_o, 0);
    write_byte(8'h5A);
    repeat (3) @(negedge clk_i);
    chk("R9 ready low", rdy_no, 0);
    chk("R4 busy", busy_o, 1);
    slave_byte(got);
    chk("R11 slave byte", got, 8'h5A);
    repeat (6) @(negedge clk_i);
    chk("R9 released", rdy_no, 1);
    chk("R4 done", busy_o, 0);

    // R6: slave drops busy between bytes
    busy_falls = 0;
    write_byte(8'h11);
    repeat (3) @(negedge clk_i);
    write_byte(8'h22);
    slave_byte(got);
    chk("R6 first", got, 8'h11);
    repeat (6) @(negedge clk_i);
    slave_byte(got);
    chk("R6 second", got, 8'h22);
    repeat (6) @(negedge clk_i);
    chk("R6 busy falls", busy_falls, 2);
    chk("R1 end idle", busy_o, 0);

    summary();
  end
endmodule